// File: doc/BRIEF.md
# Serial Flash Command Engine

This block lets software drive a serial NOR flash through a handful of memory-mapped registers. Software places up to five command bytes (an opcode, then address, mode or dummy bytes) in two buffer registers. It chooses per byte whether that byte is really driven or sent as zeros. It sets how many bytes come back from the flash and where in local memory the data lives. It then writes a control word that holds the command length, a write-data length and a start bit.

The engine lowers chip select and clocks the command out in SPI mode 0 on a single data line. It then streams the write-data bytes, fetched one at a time from local memory, and then captures the requested read bytes into local memory. Afterwards it raises chip select, holds it high for a guard interval, and sets a done flag that software polls. A command with no data at all (write-enable, power-down, wake-up) ends straight after its last command byte.

Top module: `spi_fce`

## Requirements
- R1: Command byte 0 is bits 7:0 of the low command register (offset 0), bytes 1 to 3 sit in bits 15:8, 23:16 and 31:24 of it, and byte 4 is bits 7:0 of the high command register (offset 1). Bytes leave in the order 0 to 4, each most significant bit first.
- R2: Bit i of the direction register (offset 2, bits 4:0) set sends command byte i as stored. Bit i clear sends 0x00 in that byte slot.
- R3: Writing the control word (offset 5) with bit 7 set starts a transfer. Bits 2:0 give the command length, and a value above 5 is treated as 5. Bits 27:8 give the write-data length in bytes. Exactly 8 x (command + write + read bytes) rising clock edges occur per transfer.
- R4: The write-data bytes are read from local memory at the base address (offset 4) and upward, and are sent right after the command bytes.
- R5: The read count (offset 3) keeps only its low 16 bits. That many bytes are sampled from the input line after any write data, most significant bit first, and stored to local memory from the base address upward.
- R6: Mode 0 timing: the serial clock is low whenever chip select is high, the output line changes only while the clock is low, and each clock half-period lasts HALF_CYC system cycles.
- R7: Chip select stays low for the whole transfer. It then stays high for at least 2 x GUARD_SCK x HALF_CYC cycles before the done flag is set.
- R8: The done register (offset 6) reads 1 once a transfer has finished. An accepted start clears it to 0 at the next clock edge.
- R9: A start written while a transfer or its guard interval is running is ignored and does not alter the running transfer.
- R10: With zero read and zero write bytes, the transfer ends after the last command bit.
- R11: Out of reset, chip select is high, the serial clock is low, no memory request is made and done reads 0.
- R12: The memory port requests only while chip select is low. Read data is taken one cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Local memory access request |
| mem_we | output | 1 | 1 = store, 0 = fetch |
| mem_addr | output | MEM_AW | Local memory byte address |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Fetched byte, valid one cycle after a fetch |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A register write takes effect at the first rising edge after the strobe, so the done flag reads 0 at the falling edge that follows an accepted start. Chip select falls at that same edge, and the first serial clock rise comes HALF_CYC cycles after the next one. Because the transfer length depends on byte counts, the bench does not predict the end cycle. It polls the done register at falling edges and, at the first read of 1, compares the number of cycles chip select has been high with the guard length. A flash model samples data on the serial clock's rising edge and drives its reply on the falling edge, so bit counts and byte contents are checked independently of system-cycle timing.

// File: rtl/spi_fce_pkg.sv
package spi_fce_pkg;
  localparam logic [2:0] A_CMD_LO = 3'd0;
  localparam logic [2:0] A_CMD_HI = 3'd1;
  localparam logic [2:0] A_DIR    = 3'd2;
  localparam logic [2:0] A_RDCNT  = 3'd3;
  localparam logic [2:0] A_BASE   = 3'd4;
  localparam logic [2:0] A_CTRL   = 3'd5;
  localparam logic [2:0] A_DONE   = 3'd6;
  localparam logic [2:0] MAX_CMD  = 3'd5;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WFETCH, S_WWAIT, S_WSHIFT, S_RSHIFT, S_RSTORE, S_GUARD
  } seq_state_e;
endpackage

// File: rtl/spi_fce_regs.sv
module spi_fce_regs
  import spi_fce_pkg::*;
#(
  parameter int MEM_AW = 16,
  parameter int RD_W   = 16,
  parameter int WR_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  input  logic              done,
  output logic [31:0]       rdata,
  output logic [39:0]       cmd_bytes,
  output logic [4:0]        dir_mask,
  output logic [RD_W-1:0]   rd_cnt,
  output logic [MEM_AW-1:0] base,
  output logic              start,
  output logic [2:0]        start_len,
  output logic [WR_W-1:0]   start_wlen
);
  logic [31:0]       lo_q;
  logic [7:0]        hi_q;
  logic [4:0]        dir_q;
  logic [RD_W-1:0]   rd_q;
  logic [MEM_AW-1:0] base_q;
  logic en_lo, en_hi, en_dir, en_rd, en_base;

  always_comb begin
    en_lo   = we && (addr == A_CMD_LO);
    en_hi   = we && (addr == A_CMD_HI);
    en_dir  = we && (addr == A_DIR);
    en_rd   = we && (addr == A_RDCNT);
    en_base = we && (addr == A_BASE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      dir_q  <= '0;
      rd_q   <= '0;
      base_q <= '0;
    end else begin
      if (en_lo)   lo_q   <= wdata;
      if (en_hi)   hi_q   <= wdata[7:0];
      if (en_dir)  dir_q  <= wdata[4:0];
      if (en_rd)   rd_q   <= wdata[RD_W-1:0];
      if (en_base) base_q <= wdata[MEM_AW-1:0];
    end
  end

  always_comb begin
    start      = we && (addr == A_CTRL) && wdata[7];
    start_len  = wdata[2:0];
    start_wlen = wdata[8 +: WR_W];
    cmd_bytes  = {hi_q, lo_q};
    dir_mask   = dir_q;
    rd_cnt     = rd_q;
    base       = base_q;
    case (addr)
      A_CMD_LO: rdata = lo_q;
      A_CMD_HI: rdata = {24'd0, hi_q};
      A_DIR:    rdata = {27'd0, dir_q};
      A_RDCNT:  rdata = 32'(rd_q);
      A_BASE:   rdata = 32'(base_q);
      A_DONE:   rdata = {31'd0, done};
      default:  rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/spi_fce_shifter.sv
module spi_fce_shifter #(
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic          busy_q, busy_n, hi_q, hi_n, done_q, done_n;
  logic [2:0]    bit_q, bit_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [7:0]    sr_q, sr_n, rx_q, rx_n;
  logic          tick;

  always_comb begin
    busy_n = busy_q; hi_n = hi_q; bit_n = bit_q; cnt_n = cnt_q;
    sr_n = sr_q; rx_n = rx_q; done_n = 1'b0;
    tick = busy_q && (cnt_q == CW'(HALF_CYC - 1));
    if (!busy_q) begin
      if (go) begin
        busy_n = 1'b1; hi_n = 1'b0; bit_n = 3'd0; cnt_n = '0; sr_n = tx;
      end
    end else if (tick) begin
      cnt_n = '0;
      if (!hi_q) begin
        hi_n = 1'b1;
        rx_n = {rx_q[6:0], miso};
      end else begin
        hi_n = 1'b0;
        if (bit_q == 3'd7) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end else begin
          bit_n = bit_q + 3'd1;
          sr_n  = {sr_q[6:0], 1'b0};
        end
      end
    end else begin
      cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; hi_q <= 1'b0; done_q <= 1'b0;
      bit_q <= '0; cnt_q <= '0; sr_q <= '0; rx_q <= '0;
    end else begin
      busy_q <= busy_n; hi_q <= hi_n; done_q <= done_n;
      bit_q <= bit_n; cnt_q <= cnt_n; sr_q <= sr_n; rx_q <= rx_n;
    end
  end

  assign sck  = hi_q;
  assign mosi = busy_q & sr_q[7];
  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rx_q;

  p_mosi_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q |-> $stable(mosi));
endmodule

// File: rtl/spi_fce_seq.sv
module spi_fce_seq
  import spi_fce_pkg::*;
#(
  parameter int MEM_AW    = 16,
  parameter int RD_W      = 16,
  parameter int WR_W      = 20,
  parameter int HALF_CYC  = 2,
  parameter int GUARD_SCK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        start_len,
  input  logic [WR_W-1:0]   start_wlen,
  input  logic [39:0]       cmd_bytes,
  input  logic [4:0]        dir_mask,
  input  logic [RD_W-1:0]   rd_cnt,
  input  logic [MEM_AW-1:0] base,
  input  logic              sh_busy,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  input  logic [7:0]        mem_rdata,
  output logic              sh_go,
  output logic [7:0]        sh_tx,
  output logic              cs_n,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int GUARD_CYC = 2 * GUARD_SCK * HALF_CYC;
  localparam int GW        = $clog2(GUARD_CYC + 1);

  seq_state_e        st_q, st_n;
  logic [2:0]        idx_q, idx_n, len_q, len_n;
  logic [WR_W-1:0]   wrem_q, wrem_n;
  logic [RD_W-1:0]   rrem_q, rrem_n;
  logic [MEM_AW-1:0] base_q, base_n, ptr_q, ptr_n;
  logic [GW-1:0]     gcnt_q, gcnt_n;
  logic              done_q, done_n, cs_n_q, cs_n_n;

  function automatic seq_state_e pick(input logic [WR_W-1:0] w, input logic [RD_W-1:0] r);
    if (w != '0)      return S_WFETCH;
    else if (r != '0) return S_RSHIFT;
    else              return S_GUARD;
  endfunction

  always_comb begin
    st_n = st_q; idx_n = idx_q; len_n = len_q; wrem_n = wrem_q; rrem_n = rrem_q;
    base_n = base_q; ptr_n = ptr_q; gcnt_n = '0; done_n = done_q;
    case (st_q)
      S_IDLE: if (start) begin
        len_n  = (start_len > MAX_CMD) ? MAX_CMD : start_len;
        wrem_n = start_wlen; rrem_n = rd_cnt;
        base_n = base; ptr_n = base; idx_n = 3'd0; done_n = 1'b0;
        st_n   = (len_n != 3'd0) ? S_CMD : pick(start_wlen, rd_cnt);
      end
      S_CMD: if (sh_done) begin
        if (idx_q == len_q - 3'd1) st_n = pick(wrem_q, rrem_q);
        else idx_n = idx_q + 3'd1;
      end
      S_WFETCH: st_n = S_WWAIT;
      S_WWAIT:  st_n = S_WSHIFT;
      S_WSHIFT: if (sh_done) begin
        wrem_n = wrem_q - WR_W'(1);
        ptr_n  = ptr_q + MEM_AW'(1);
        if (wrem_q == WR_W'(1)) begin
          if (rrem_q != '0) begin st_n = S_RSHIFT; ptr_n = base_q; end
          else st_n = S_GUARD;
        end else st_n = S_WFETCH;
      end
      S_RSHIFT: if (sh_done) st_n = S_RSTORE;
      S_RSTORE: begin
        rrem_n = rrem_q - RD_W'(1);
        ptr_n  = ptr_q + MEM_AW'(1);
        st_n   = (rrem_q == RD_W'(1)) ? S_GUARD : S_RSHIFT;
      end
      S_GUARD: begin
        gcnt_n = gcnt_q + GW'(1);
        if (gcnt_q == GW'(GUARD_CYC - 1)) begin
          done_n = 1'b1; st_n = S_IDLE; gcnt_n = '0;
        end
      end
      default: st_n = S_IDLE;
    endcase
    cs_n_n = (st_n == S_IDLE) || (st_n == S_GUARD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; idx_q <= '0; len_q <= '0; wrem_q <= '0; rrem_q <= '0;
      base_q <= '0; ptr_q <= '0; gcnt_q <= '0; done_q <= 1'b0; cs_n_q <= 1'b1;
    end else begin
      st_q <= st_n; idx_q <= idx_n; len_q <= len_n; wrem_q <= wrem_n; rrem_q <= rrem_n;
      base_q <= base_n; ptr_q <= ptr_n; gcnt_q <= gcnt_n; done_q <= done_n; cs_n_q <= cs_n_n;
    end
  end

  always_comb begin
    sh_go = (((st_q == S_CMD) || (st_q == S_RSHIFT)) && !sh_busy && !sh_done)
            || (st_q == S_WWAIT);
    case (st_q)
      S_CMD:   sh_tx = dir_mask[idx_q] ? cmd_bytes[idx_q*8 +: 8] : 8'h00;
      S_WWAIT: sh_tx = mem_rdata;
      default: sh_tx = 8'h00;
    endcase
    mem_req   = (st_q == S_WFETCH) || (st_q == S_RSTORE);
    mem_we    = (st_q == S_RSTORE);
    mem_addr  = ptr_q;
    mem_wdata = sh_rx;
    cs_n      = cs_n_q;
    done      = done_q;
  end

  // Checker state: consecutive cycles with chip select high (saturating).
  logic [GW-1:0] hi_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            hi_cnt_q <= '0;
    else if (!cs_n_q)                      hi_cnt_q <= '0;
    else if (hi_cnt_q != GW'(GUARD_CYC))   hi_cnt_q <= hi_cnt_q + GW'(1);
  end

  p_guard_before_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (hi_cnt_q >= GW'(GUARD_CYC)));
  p_mem_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !mem_req);
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (st_q == S_IDLE)) |=> !done_q);
  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (st_q != S_IDLE) && (st_q != S_GUARD)) |=> !cs_n_q);
endmodule

// File: rtl/spi_fce.sv
module spi_fce
  import spi_fce_pkg::*;
#(
  parameter int MEM_AW    = 16,
  parameter int RD_W      = 16,
  parameter int WR_W      = 20,
  parameter int HALF_CYC  = 2,
  parameter int GUARD_SCK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [39:0]       cmd_bytes;
  logic [4:0]        dir_mask;
  logic [RD_W-1:0]   rd_cnt;
  logic [MEM_AW-1:0] base;
  logic              start, done, sh_go, sh_busy, sh_done;
  logic [2:0]        start_len;
  logic [WR_W-1:0]   start_wlen;
  logic [7:0]        sh_tx, sh_rx;

  spi_fce_regs #(.MEM_AW(MEM_AW), .RD_W(RD_W), .WR_W(WR_W)) regs_i (
    .clk(clk), .rst_n(rst_i), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .done(done), .rdata(reg_rdata), .cmd_bytes(cmd_bytes), .dir_mask(dir_mask),
    .rd_cnt(rd_cnt), .base(base), .start(start), .start_len(start_len),
    .start_wlen(start_wlen));

  spi_fce_seq #(.MEM_AW(MEM_AW), .RD_W(RD_W), .WR_W(WR_W), .HALF_CYC(HALF_CYC),
                .GUARD_SCK(GUARD_SCK)) seq_i (
    .clk(clk), .rst_n(rst_i), .start(start), .start_len(start_len),
    .start_wlen(start_wlen), .cmd_bytes(cmd_bytes), .dir_mask(dir_mask),
    .rd_cnt(rd_cnt), .base(base), .sh_busy(sh_busy), .sh_done(sh_done),
    .sh_rx(sh_rx), .mem_rdata(mem_rdata), .sh_go(sh_go), .sh_tx(sh_tx),
    .cs_n(spi_cs_n), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  spi_fce_shifter #(.HALF_CYC(HALF_CYC)) sh_i (
    .clk(clk), .rst_n(rst_i), .go(sh_go), .tx(sh_tx), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .busy(sh_busy), .done(sh_done), .rx(sh_rx));

  p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_i)
    spi_cs_n |-> !spi_sck);
  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(rst_i) |-> (spi_cs_n && !mem_req));
endmodule

// File: tb/spi_fce_tb_top.sv
module spi_fce_tb_top;
  localparam int HALF  = 2;
  localparam int GUARD = 4 * HALF;

  typedef struct packed {
    logic [31:0] lo;
    logic [7:0]  hi;
    logic [4:0]  dir;
    logic [2:0]  len;
    logic [7:0]  wr;
    logic [7:0]  rd;
    logic [7:0]  base;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0006, 8'h00, 5'h01, 3'd1, 8'd0, 8'd0, 8'h00},
    '{32'h5634_120B, 8'hA5, 5'h1F, 3'd5, 8'd0, 8'd4, 8'h80},
    '{32'h0010_0002, 8'h00, 5'h0F, 3'd4, 8'd6, 8'd0, 8'h10},
    '{32'hDDCC_BBAA, 8'h00, 5'h05, 3'd4, 8'd0, 8'd2, 8'h90},
    '{32'h4433_2211, 8'h55, 5'h1F, 3'd7, 8'd0, 8'd0, 8'h00},
    '{32'h0000_0000, 8'h00, 5'h00, 3'd0, 8'd3, 8'd2, 8'h20}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;
  logic [7:0] mem_addr, mem_wdata;
  logic [7:0] mem_rdata;
  logic [7:0] mem [256];

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  spi_fce #(.MEM_AW(8), .HALF_CYC(HALF), .GUARD_SCK(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  // Local memory model: one-cycle fetch latency.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  function automatic logic [7:0] pat(input int g);
    return 8'(g * 29 + 90);
  endfunction

  // Flash model: samples on rising clock, answers on falling clock.
  int nb = 0;
  logic [7:0] cur = 8'd0;
  logic [7:0] log_mem [1024];
  always @(posedge spi_sck) begin
    cur = {cur[6:0], spi_mosi};
    if (nb % 8 == 7) log_mem[(nb / 8) % 1024] = cur;
    nb = nb + 1;
  end
  logic [7:0] pb;
  always @(negedge spi_sck or negedge spi_cs_n) begin
    pb = pat(nb / 8);
    spi_miso <= pb[7 - (nb % 8)];
  end

  int cs_hi_run = 0;
  always @(posedge clk) cs_hi_run <= spi_cs_n ? cs_hi_run + 1 : 0;

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_done(output int guard_seen);
    logic [31:0] d;
    guard_seen = -1;
    for (int t = 0; t < 20000; t++) begin
      rd(3'd6, d);
      if (d == 32'd1) begin guard_seen = cs_hi_run; return; end
    end
    check(1'b0, "R8 done timeout", 0, 1);
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    int leff, nb0, g0, tot, bad, gs;
    logic [7:0] snap [8];
    logic [7:0] e;
    logic [31:0] d;
    v = VEC[i];
    leff = (v.len > 3'd5) ? 5 : int'(v.len);
    for (int k = 0; k < 8; k++) snap[k] = mem[8'(v.base + k)];
    wr(3'd0, v.lo); wr(3'd1, {24'd0, v.hi}); wr(3'd2, {27'd0, v.dir});
    wr(3'd3, {24'd0, v.rd}); wr(3'd4, {24'd0, v.base});
    nb0 = nb; g0 = nb0 / 8;
    wr(3'd5, (32'(v.wr) << 8) | 32'h80 | 32'(v.len));
    rd(3'd6, d);
    check(d == 32'd0, "R8 done cleared by start", d, 0);
    wait_done(gs);
    check(gs >= GUARD, "R7 guard before done", gs, GUARD);
    tot = leff + v.wr + v.rd;
    check(nb - nb0 == 8 * tot, (v.wr == 0 && v.rd == 0) ? "R10 clock count" : "R3 clock count",
          nb - nb0, 8 * tot);
    bad = 0;
    for (int k = 0; k < tot; k++) begin
      if (k < leff) e = v.dir[k] ? ((k == 4) ? v.hi : v.lo[k*8 +: 8]) : 8'h00;
      else if (k < leff + v.wr) e = snap[k - leff];
      else e = 8'h00;
      if (log_mem[(g0 + k) % 1024] != e) begin
        bad++;
        $display("FAIL R1 R2 R4 vec %0d byte %0d: actual %0h expected %0h", i, k,
                 log_mem[(g0 + k) % 1024], e);
      end
    end
    n_chk++; if (bad != 0) n_err++;
    if (v.rd != 0) begin
      bad = 0;
      for (int r = 0; r < v.rd; r++) begin
        e = pat(g0 + leff + v.wr + r);
        if (mem[8'(v.base + r)] != e) begin
          bad++;
          $display("FAIL R5 vec %0d byte %0d: actual %0h expected %0h", i, r,
                   mem[8'(v.base + r)], e);
        end
      end
      n_chk++; if (bad != 0) n_err++;
    end
  endtask

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int nb0, gs;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(spi_cs_n == 1'b1, "R11 cs high", spi_cs_n, 1);
    check(spi_sck == 1'b0, "R11 sck low", spi_sck, 0);
    check(mem_req == 1'b0, "R11 no mem req", mem_req, 0);
    rd(3'd6, d);
    check(d == 32'd0, "R11 done zero", d, 0);
    // R5 read count keeps 16 bits
    wr(3'd3, 32'h0001_2345);
    rd(3'd3, d);
    check(d == 32'h2345, "R5 read count width", d, 32'h2345);
    // table walk (R1 R2 R3 R4 R5 R6 R7 R8 R10 R12)
    for (int i = 0; i < NV; i++) run_vec(i);
    // R9 start while busy
    wr(3'd0, 32'h0000_0003); wr(3'd2, 32'h1); wr(3'd3, 32'd4); wr(3'd4, 32'hC0);
    nb0 = nb;
    wr(3'd5, 32'h0000_0081);
    repeat (10) @(negedge clk);
    wr(3'd5, 32'h0000_0385);
    rd(3'd6, d);
    check(d == 32'd0, "R9 done stays 0 while busy", d, 0);
    wait_done(gs);
    check(nb - nb0 == 8 * 5, "R9 busy start ignored", nb - nb0, 40);
    check(mem[8'hC0] == pat(nb0 / 8 + 1), "R9 R5 stored first byte", mem[8'hC0], pat(nb0 / 8 + 1));
    check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R6 idle after transfer", spi_sck, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule